// File: doc/BRIEF.md
# Aliased partial-width register file

This block is a small general-purpose register file. It holds four 32-bit registers. Each register can be reached through four overlapping views: the whole 32-bit word, its low 16-bit half, the upper byte of that half (bits 15..8), or the lower byte (bits 7..0). The views are aliases of one storage word. A narrow write changes only the bits of its view, and every other bit of the word keeps its value. No view covers bits 31..16 alone, so those bits change only on a full-word write.

There is one write port and two independent read ports. Each port takes a register index and a 2-bit part selector. A write takes effect on the rising clock edge when write-enable is high. Reads are combinational. A narrow read is shifted down to bit 0 and zero-extended to 32 bits. A read of a register in the cycle of a write to it returns the value from before the write.

Top module: `aliased_regfile`

## Requirements
- R1: A synchronous active-high reset `rst` clears all four registers to zero at the next rising edge.
- R2: With part code 00 (full word), a write replaces all 32 bits of register `wrIdx` with `wrData`. Register codes are A=0, B=1, C=2, D=3.
- R3: With part code 01 (low half), a write loads bits 15..0 from `wrData[15:0]` and leaves bits 31..16 unchanged.
- R4: With part code 10 (high byte), a write loads bits 15..8 from `wrData[7:0]` and leaves bits 31..16 and 7..0 unchanged.
- R5: With part code 11 (low byte), a write loads bits 7..0 from `wrData[7:0]` and leaves bits 31..8 unchanged.
- R6: No register changes while `wrEn` is low. A write never changes any register other than the one `wrIdx` selects.
- R7: Reads are combinational and follow these rules by part code:
  - 00 returns the whole word.
  - 01 returns bits 15..0 in the low 16 output bits, with zeros above.
  - 10 returns bits 15..8 in the low 8 output bits, with zeros above.
  - 11 returns bits 7..0 in the low 8 output bits, with zeros above.
- R8: The two read ports work independently. Each port can select any register and any part in the same cycle as the other.
- R9: A read of the register being written returns the old value during the write cycle. The new value is visible from the following cycle.
- R10: The sequence "write 0x12 to the high byte of A, then write 0x34 to the low byte of A" leaves the low-half view of A reading 0x1234. Bits 31..16 of A are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 2 | Register to write (A=0, B=1, C=2, D=3) |
| wrPart | input | 2 | Part to write: 00 word, 01 low half, 10 high byte, 11 low byte |
| wrData | input | 32 | Write data; narrow writes take their bits from the low end |
| rdIdxA | input | 2 | Register read on port A |
| rdPartA | input | 2 | Part read on port A |
| rdDataA | output | 32 | Port A data, right-aligned and zero-extended |
| rdIdxB | input | 2 | Register read on port B |
| rdPartB | input | 2 | Part read on port B |
| rdDataB | output | 32 | Port B data, right-aligned and zero-extended |

## Verification
Every register is written with every part code. The data patterns include all-ones, all-zeros and several mixed words. Writing all-ones over zeros, and then zeros over ones, shows whether a narrow write spills into bits it must keep. The mixed patterns separate the two bytes of the low half, and they expose a high-byte write that takes its data from the wrong input bits.

After each write, every register is read through every view on both ports. The two ports are driven with different selections, so a wrong register, a wrong alignment or a coupling between the ports shows up. A write attempt with enable low and the byte sequence from R10 close the sweep.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int RF_W     = 32;
  localparam int RF_LANES = 3;   // lane0 = bits 7..0, lane1 = bits 15..8, lane2 = bits 31..16

  typedef enum logic [1:0] {
    PART_FULL = 2'b00,
    PART_HALF = 2'b01,
    PART_HIB  = 2'b10,
    PART_LOB  = 2'b11
  } rf_part_e;

  typedef struct packed {
    logic [RF_LANES-1:0] laneEn;
    logic [RF_W-1:0]     wrData;
  } rf_strobe_t;

  function automatic int laneOf(input int bitPos);
    if (bitPos < 8) return 0;
    else if (bitPos < 16) return 1;
    else return 2;
  endfunction
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import regfile_pkg::*;
#(
  parameter int IDX_W = 2,
  localparam int REG_COUNT = 1 << IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [1:0]           wrPart,
  input  logic [RF_W-1:0]      wrData,
  output logic [REG_COUNT-1:0] regSel,
  output rf_strobe_t           strb
);
  rf_part_e part;
  assign part = rf_part_e'(wrPart);

  always_comb begin
    regSel = '0;
    if (wrEn) regSel[wrIdx] = 1'b1;
  end

  always_comb begin
    strb.wrData = wrData;
    unique case (part)
      PART_FULL: strb.laneEn = 3'b111;
      PART_HALF: strb.laneEn = 3'b011;
      PART_HIB: begin
        strb.laneEn = 3'b010;
        strb.wrData = {{(RF_W-16){1'b0}}, wrData[7:0], 8'h00};
      end
      default:   strb.laneEn = 3'b001;
    endcase
  end

  // R6: at most one register is targeted per cycle
  assert_one_target_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(regSel));

  // R3: the upper half is only ever touched by a full-word write
  assert_upper_only_full_R3: assert property (@(posedge clk) disable iff (rst)
    (wrEn && strb.laneEn[2]) |-> (wrPart == 2'b00));
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import regfile_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int NUM_RD = 2,
  localparam int REG_COUNT = 1 << IDX_W
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [REG_COUNT-1:0]               regSel,
  input  rf_strobe_t                         strb,
  input  logic [NUM_RD-1:0][IDX_W-1:0]       rdIdx,
  input  logic [NUM_RD-1:0][1:0]             rdPart,
  output logic [NUM_RD-1:0][RF_W-1:0]        rdData
);
  logic [RF_W-1:0] store [REG_COUNT];
  logic [RF_W-1:0] bitMask;

  for (genvar b = 0; b < RF_W; b++) begin : g_mask
    assign bitMask[b] = strb.laneEn[laneOf(b)];
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic [RF_W-1:0] merged;
    assign merged = (store[g] & ~bitMask) | (strb.wrData & bitMask);

    always_ff @(posedge clk) begin
      if (rst)            store[g] <= '0;
      else if (regSel[g]) store[g] <= merged;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (store[g] == '0));

    assert_full_write_R2: assert property (@(posedge clk) disable iff (rst)
      (regSel[g] && strb.laneEn == 3'b111) |=> (store[g] == $past(strb.wrData)));

    assert_hib_write_R4: assert property (@(posedge clk) disable iff (rst)
      (regSel[g] && strb.laneEn == 3'b010) |=> (store[g][15:8] == $past(strb.wrData[15:8])));

    assert_lob_write_R5: assert property (@(posedge clk) disable iff (rst)
      (regSel[g] && strb.laneEn == 3'b001) |=> (store[g][7:0] == $past(strb.wrData[7:0])));

    assert_keep_low_R6: assert property (@(posedge clk) disable iff (rst)
      !(regSel[g] && strb.laneEn[0]) |=> $stable(store[g][7:0]));
    assert_keep_mid_R6: assert property (@(posedge clk) disable iff (rst)
      !(regSel[g] && strb.laneEn[1]) |=> $stable(store[g][15:8]));
    assert_keep_upper_R3: assert property (@(posedge clk) disable iff (rst)
      !(regSel[g] && strb.laneEn[2]) |=> $stable(store[g][RF_W-1:16]));
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [RF_W-1:0] word;
    assign word = store[rdIdx[p]];
    always_comb begin
      unique case (rf_part_e'(rdPart[p]))
        PART_FULL: rdData[p] = word;
        PART_HALF: rdData[p] = {{(RF_W-16){1'b0}}, word[15:0]};
        PART_HIB:  rdData[p] = {{(RF_W-8){1'b0}}, word[15:8]};
        default:   rdData[p] = {{(RF_W-8){1'b0}}, word[7:0]};
      endcase
    end

    // R7: narrow views are zero-extended
    assert_byte_zext_R7: assert property (@(posedge clk) disable iff (rst)
      (rdPart[p][1]) |-> (rdData[p][RF_W-1:8] == '0));
    assert_half_zext_R7: assert property (@(posedge clk) disable iff (rst)
      (rdPart[p] == 2'b01) |-> (rdData[p][RF_W-1:16] == '0));
  end
endmodule

// File: rtl/aliased_regfile.sv
module aliased_regfile
  import regfile_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [1:0]  wrIdx,
  input  logic [1:0]  wrPart,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdIdxA,
  input  logic [1:0]  rdPartA,
  output logic [31:0] rdDataA,
  input  logic [1:0]  rdIdxB,
  input  logic [1:0]  rdPartB,
  output logic [31:0] rdDataB
);
  localparam int IDX_W     = 2;
  localparam int NUM_RD    = 2;
  localparam int REG_COUNT = 1 << IDX_W;

  logic [REG_COUNT-1:0]        regSel;
  rf_strobe_t                  strb;
  logic [NUM_RD-1:0][RF_W-1:0] rdBus;

  rf_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrPart(wrPart),
    .wrData(wrData), .regSel(regSel), .strb(strb)
  );

  rf_datapath #(.IDX_W(IDX_W), .NUM_RD(NUM_RD)) u_dp (
    .clk(clk), .rst(rst), .regSel(regSel), .strb(strb),
    .rdIdx({rdIdxB, rdIdxA}), .rdPart({rdPartB, rdPartA}), .rdData(rdBus)
  );

  assign rdDataA = rdBus[0];
  assign rdDataB = rdBus[1];
endmodule

// File: tb/tb_aliased_regfile.sv
module tb_aliased_regfile;
  logic        clk = 1'b0;
  logic        rst, wrEn;
  logic [1:0]  wrIdx, wrPart, rdIdxA, rdPartA, rdIdxB, rdPartB;
  logic [31:0] wrData, rdDataA, rdDataB;
  logic [31:0] model [4];
  int tests = 0;
  int fails = 0;

  aliased_regfile dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrPart(wrPart),
    .wrData(wrData), .rdIdxA(rdIdxA), .rdPartA(rdPartA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdPartB(rdPartB), .rdDataB(rdDataB)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] expWrite(logic [31:0] old, int part, logic [31:0] d);
    case (part)
      0: return d;
      1: return (old & 32'hFFFF_0000) | (d & 32'h0000_FFFF);
      2: return (old & 32'hFFFF_00FF) | ((d & 32'hFF) << 8);
      default: return (old & 32'hFFFF_FF00) | (d & 32'hFF);
    endcase
  endfunction

  function automatic logic [31:0] expView(logic [31:0] v, int part);
    case (part)
      0: return v;
      1: return v % 32'h1_0000;
      2: return (v / 32'h100) % 32'h100;
      default: return v % 32'h100;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // R7 / R8: every view of every register on both ports, ports on different selections
  task automatic verifyAll(string req);
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < 4; p++) begin
        rdIdxA = 2'(r);     rdPartA = 2'(p);
        rdIdxB = 2'(3 - r); rdPartB = 2'(3 - p);
        #1;
        chk(req, rdDataA, expView(model[r], p));
        chk(req, rdDataB, expView(model[3 - r], 3 - p));
      end
    end
  endtask

  task automatic doWrite(int idx, int part, logic [31:0] d, bit en);
    @(negedge clk);
    wrEn = en; wrIdx = 2'(idx); wrPart = 2'(part); wrData = d;
    rdIdxA = 2'(idx); rdPartA = 2'b00;
    #1;
    chk("R9 old value during write", rdDataA, model[idx]);
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    if (en) model[idx] = expWrite(model[idx], part, d);
    chk("R9 new value next cycle", rdDataA, model[idx]);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats [6];
    string tag;
    pats[0] = 32'hFFFF_FFFF;
    pats[1] = 32'h0000_0000;
    pats[2] = 32'hA5C3_5A3C;
    pats[3] = 32'h1357_9BDF;
    pats[4] = 32'h8001_7FFE;
    pats[5] = 32'h6E2D_F10B;
    rst = 1'b1; wrEn = 1'b0; wrIdx = '0; wrPart = '0; wrData = 32'hDEAD_BEEF;
    rdIdxA = '0; rdPartA = '0; rdIdxB = '0; rdPartB = '0;
    for (int i = 0; i < 4; i++) model[i] = 32'h0;
    // make the registers non-zero, then check that reset clears them (R1)
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) doWrite(i, 0, 32'h1111_1111 * (i + 3), 1'b1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    for (int i = 0; i < 4; i++) model[i] = 32'h0;
    verifyAll("R1 reset clears");

    // sweep: every register, every part, every pattern
    for (int k = 0; k < 6; k++) begin
      for (int r = 0; r < 4; r++) begin
        for (int p = 0; p < 4; p++) begin
          case (p)
            0: tag = "R2 full write";
            1: tag = "R3 half write keeps upper";
            2: tag = "R4 high byte write";
            default: tag = "R5 low byte write";
          endcase
          doWrite(r, p, pats[k] ^ (32'h0101_0101 * (r + p)), 1'b1);
          verifyAll(tag);
        end
      end
    end

    // R6: enable low changes nothing
    for (int p = 0; p < 4; p++) begin
      doWrite(p, p, ~model[p], 1'b0);
      verifyAll("R6 disabled write ignored");
    end

    // R10: byte sequence on A
    doWrite(0, 0, 32'hCAFE_0000, 1'b1);
    doWrite(0, 2, 32'h0000_0012, 1'b1);
    doWrite(0, 3, 32'h0000_0034, 1'b1);
    rdIdxA = 2'd0; rdPartA = 2'b01; rdIdxB = 2'd0; rdPartB = 2'b00;
    #1;
    chk("R10 half view of A", rdDataA, 32'h0000_1234);
    chk("R10 upper kept", rdDataB, 32'hCAFE_1234);
    verifyAll("R8 both ports after sequence");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule